// File: doc/BRIEF.md
# Current-Source Inverter Zero-State Hysteresis Selector and Gate Decoder

This block drives the six power switches of a single-phase current-source inverter. Each cycle it takes two modulation bits from the PWM generator (`pwm_a`, `pwm_b`), the sampled DC-link inductor current, and two programmable band limits. From these it produces registered gate enables. When the modulator asks for a positive or a negative output, the decoder selects the matching active bridge pattern. When it asks for zero output, a hysteresis state bit chooses one of two zero patterns. One pattern charges the inductor. The other discharges it. This holds the link current inside the band, so the zero interval does not simply freewheel.

The inductor current is compared with an upper and a lower limit, and both results are registered. The comparator flags then update the state bit. Current above the upper limit clears it, which selects the discharging pattern. Current below the lower limit sets it, which selects the charging pattern. The modulation bits are delayed so that they line up with the state bit. The decoded gate vector is registered once more before it leaves the block. The ADC, dead-time insertion and the PWM carriers are outside the block.

Top module: `csi_hyst_gate`

## Requirements
- R1: While reset is asserted and after it is released, until new inputs reach the outputs, `gate_o` equals 6'b000011 (switches 1 and 2 on, the charging path) and the state bit is 1.
- R2: The inductor current and both limits are signed two's-complement `CUR_W`-bit numbers. The over flag is true only when the current is strictly greater than `band_hi`. The under flag is true only when the current is strictly less than `band_lo`. Equality raises neither flag.
- R3: An under flag without an over flag sets the state bit on the next clock.
- R4: An over flag clears the state bit on the next clock.
- R5: With neither flag raised, the state bit keeps its value.
- R6: When both flags are raised in the same cycle, the state bit is cleared.
- R7: The code {pwm_a,pwm_b} = 2'b11 gives `gate_o` = 6'b001001 (switches 1 and 4 on, positive output).
- R8: The code {pwm_a,pwm_b} = 2'b00 gives `gate_o` = 6'b000110 (switches 2 and 3 on, negative output).
- R9: The code {pwm_a,pwm_b} = 2'b01 is the zero state. With the state bit at 1 it gives 6'b000011 (charging). With the state bit at 0 it gives 6'b110000 (switches 5 and 6 on, discharging).
- R10: The code {pwm_a,pwm_b} = 2'b10 gives `gate_o` = 6'b000000.
- R11: Latency is the same on both paths. Inputs sampled at clock edge k determine `gate_o` after edge k+2. The current affects the state bit at edge k+1, and the gates at edge k+2.
- R12: Switch 5 always equals switch 6. Neither of them is ever on in a cycle in which switch 1 or switch 2 is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_a | input | 1 | Modulation bit A (high bit of the mode code) |
| pwm_b | input | 1 | Modulation bit B (low bit of the mode code) |
| i_meas | input | CUR_W (16) | Sampled inductor current, signed |
| band_hi | input | CUR_W (16) | Upper hysteresis limit, signed |
| band_lo | input | CUR_W (16) | Lower hysteresis limit, signed |
| gate_o | output | 6 | Gate enables; bit n drives switch n+1 |

## Verification
Two events can fall in the same clock and contend: a band crossing that flips the state bit, and a change of the modulation code into or out of the zero state. They meet in the cycle where the decoder reads both.

The bench provokes this meeting by driving a pseudo-random sequence. Both the code and a current around a narrow band change on every clock, so crossings often coincide with entries into the zero state. It also inverts the band limits so that both comparator flags are raised at once.

Each output is judged against a cycle-accurate reference in the bench. The reference applies the set/clear rule and the per-code switch table. It keeps the same two-edge alignment, and it checks on every cycle that the discharging pair is never on together with the charging pair.

// File: rtl/csi_hyst_pkg.sv
package csi_hyst_pkg;

  localparam int GATE_N   = 6;
  // register stages between an input edge and the state bit (compare + set/reset)
  localparam int AB_ALIGN = 2;

  // mode code is {A,B}
  typedef enum logic [1:0] {
    MODE_NEG  = 2'b00,
    MODE_ZERO = 2'b01,
    MODE_IDLE = 2'b10,
    MODE_POS  = 2'b11
  } mode_e;

  typedef struct packed {
    logic over;
    logic under;
  } band_flags_t;

  localparam logic [GATE_N-1:0] GATE_RESET = 6'b000011;
  localparam logic [1:0]        MODE_RESET = 2'b01;

  // switch equations, bit n = switch n+1
  function automatic logic [GATE_N-1:0] gate_decode(input logic a, input logic b,
                                                    input logic q);
    logic [GATE_N-1:0] g;
    g[0] = b & (a | q);
    g[1] = ~a & (~b | q);
    g[2] = ~a & ~b;
    g[3] = a & b;
    g[4] = ~a & b & ~q;
    g[5] = ~a & b & ~q;
    return g;
  endfunction

  // set on under, clear on over, clear wins when both
  function automatic logic next_zq(input logic q, input band_flags_t f);
    logic n;
    if (f.over)       n = 1'b0;
    else if (f.under) n = 1'b1;
    else              n = q;
    return n;
  endfunction

endpackage

// File: rtl/csi_band_cmp.sv
module csi_band_cmp
  import csi_hyst_pkg::*;
#(
  parameter int CUR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [CUR_W-1:0] i_meas,
  input  logic signed [CUR_W-1:0] band_hi,
  input  logic signed [CUR_W-1:0] band_lo,
  output band_flags_t             flags_o
);

  function automatic logic above_lim(input logic signed [CUR_W-1:0] x,
                                     input logic signed [CUR_W-1:0] lim);
    return x > lim;
  endfunction

  function automatic logic below_lim(input logic signed [CUR_W-1:0] x,
                                     input logic signed [CUR_W-1:0] lim);
    return x < lim;
  endfunction

  band_flags_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q.over  <= above_lim(i_meas, band_hi);
      flags_q.under <= below_lim(i_meas, band_lo);
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/csi_zero_sel.sv
module csi_zero_sel
  import csi_hyst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  band_flags_t flags_i,
  output logic        zq_o
);

  logic zq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zq_q <= 1'b1;
    else        zq_q <= next_zq(zq_q, flags_i);
  end

  assign zq_o = zq_q;

endmodule

// File: rtl/csi_gate_dec.sv
module csi_gate_dec
  import csi_hyst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_a,
  input  logic              pwm_b,
  input  logic              zq_i,
  output logic [GATE_N-1:0] gate_o
);

  // mode delay so the code meets the state bit derived from the same edge
  logic [1:0] ab_dly [AB_ALIGN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < AB_ALIGN; k++) ab_dly[k] <= MODE_RESET;
    end else begin
      ab_dly[0] <= {pwm_a, pwm_b};
      for (int k = 1; k < AB_ALIGN; k++) ab_dly[k] <= ab_dly[k-1];
    end
  end

  logic [GATE_N-1:0] gate_next;
  assign gate_next = gate_decode(ab_dly[AB_ALIGN-1][1], ab_dly[AB_ALIGN-1][0], zq_i);

  for (genvar g = 0; g < GATE_N; g++) begin : g_out
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= GATE_RESET[g];
      else        bit_q <= gate_next[g];
    end
    assign gate_o[g] = bit_q;
  end

endmodule

// File: rtl/csi_hyst_gate.sv
module csi_hyst_gate
  import csi_hyst_pkg::*;
#(
  parameter int CUR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwm_a,
  input  logic                    pwm_b,
  input  logic signed [CUR_W-1:0] i_meas,
  input  logic signed [CUR_W-1:0] band_hi,
  input  logic signed [CUR_W-1:0] band_lo,
  output logic [GATE_N-1:0]       gate_o
);

  band_flags_t flags_w;
  logic        over_w;
  logic        under_w;
  logic        zq_w;

  csi_band_cmp #(.CUR_W(CUR_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_meas  (i_meas),
    .band_hi (band_hi),
    .band_lo (band_lo),
    .flags_o (flags_w)
  );

  assign over_w  = flags_w.over;
  assign under_w = flags_w.under;

  csi_zero_sel u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (flags_w),
    .zq_o    (zq_w)
  );

  csi_gate_dec u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwm_a  (pwm_a),
    .pwm_b  (pwm_b),
    .zq_i   (zq_w),
    .gate_o (gate_o)
  );

endmodule

// File: rtl/csi_hyst_gate_chk.sv
module csi_hyst_gate_chk
  import csi_hyst_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_a,
  input logic              pwm_b,
  input logic [GATE_N-1:0] gate_o,
  input logic              over_w,
  input logic              under_w,
  input logic              zq_w
);

  logic [1:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd3);

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (under_w && !over_w) |=> zq_w);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    over_w |=> !zq_w);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!over_w && !under_w) |=> $stable(zq_w));

  p_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (over_w && under_w) |=> !zq_w);

  p_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(pwm_a, 3) && $past(pwm_b, 3)) |-> (gate_o == 6'b001001));

  p_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(pwm_a, 3) && !$past(pwm_b, 3)) |-> (gate_o == 6'b000110));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(pwm_a, 3) && !$past(pwm_b, 3)) |-> (gate_o == 6'b000000));

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o[4] || gate_o[5]) |-> !(gate_o[0] || gate_o[1]));

  p_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o[4] == gate_o[5]);

endmodule

bind csi_hyst_gate csi_hyst_gate_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwm_a   (pwm_a),
  .pwm_b   (pwm_b),
  .gate_o  (gate_o),
  .over_w  (over_w),
  .under_w (under_w),
  .zq_w    (zq_w)
);

// File: tb/csi_hyst_gate_tb.sv
module csi_hyst_gate_tb;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               a = 1'b0;
  logic               b = 1'b1;
  logic signed [15:0] cur = 16'sd0;
  logic signed [15:0] hi  = 16'sd3;
  logic signed [15:0] lo  = -16'sd3;
  logic [5:0]         gate_o;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [1:0] m_ab1 = 2'b01, m_ab2 = 2'b01;
  logic       m_over = 1'b0, m_under = 1'b0, m_q = 1'b1;
  logic [5:0] m_gate = 6'b000011;

  always #4 clk = ~clk;

  csi_hyst_gate u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_a(a), .pwm_b(b),
    .i_meas(cur), .band_hi(hi), .band_lo(lo), .gate_o(gate_o)
  );

  // switch table per mode (R7..R10)
  function automatic logic [5:0] exp_gate(input logic [1:0] ab, input logic q);
    case (ab)
      2'b11:   return 6'b001001;
      2'b00:   return 6'b000110;
      2'b10:   return 6'b000000;
      default: return q ? 6'b000011 : 6'b110000;
    endcase
  endfunction

  task automatic check_gate(input string tag);
    checks++;
    if (gate_o !== m_gate) begin
      errors++;
      $display("FAIL %s gate actual=%b expected=%b", tag, gate_o, m_gate);
    end
    checks++;
    if ((gate_o[4] !== gate_o[5]) || ((gate_o[4] | gate_o[5]) & (gate_o[0] | gate_o[1]))) begin
      errors++;
      $display("FAIL R12 gate actual=%b expected=no 5/6 with 1/2", gate_o);
    end
  endtask

  // one clock: reference follows the two-edge alignment of R11
  task automatic tick(input string tag);
    @(posedge clk);
    m_gate = exp_gate(m_ab2, m_q);
    if (m_over)       m_q = 1'b0;
    else if (m_under) m_q = 1'b1;
    m_ab2   = m_ab1;
    m_over  = (cur > hi);
    m_under = (cur < lo);
    m_ab1   = {a, b};
    @(negedge clk);
    check_gate(tag);
  endtask

  task automatic drive(input logic [1:0] ab, input int i);
    {a, b} = ab;
    cur = 16'(i);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    check_gate("R1");
    rst_n = 1'b1;
    tick("R1");
    tick("R1");

    // each mode with current inside the band
    for (int m = 0; m < 4; m++) begin
      drive(2'(m), 0);
      for (int r = 0; r < 4; r++)
        tick(m == 3 ? "R7" : m == 0 ? "R8" : m == 2 ? "R10" : "R9");
    end

    // R2: sweep across a small band, including both equality points
    hi = 16'sd3; lo = -16'sd3;
    for (int i = -6; i <= 6; i++) begin
      drive(2'b01, i);
      tick("R2");
      drive(2'b01, 0);
      tick("R2");
      tick("R2");
    end
    // R2: negative band, sign handling
    hi = -16'sd100; lo = -16'sd200;
    for (int i = -210; i <= -90; i += 10) begin
      drive(2'b01, i);
      tick("R2");
      tick("R2");
      tick("R2");
    end
    // R2: extreme limits never trigger
    hi = 16'sh7fff; lo = 16'sh8000;
    drive(2'b01, 32767);  tick("R2"); tick("R2"); tick("R2");
    drive(2'b01, -32768); tick("R2"); tick("R2"); tick("R2");

    // R3/R4/R5: single-cycle pulses, then holding
    hi = 16'sd3; lo = -16'sd3;
    drive(2'b01, 9);  tick("R4");
    drive(2'b01, 0);  repeat (4) tick("R5");
    drive(2'b01, -9); tick("R3");
    drive(2'b01, 0);  repeat (4) tick("R5");
    drive(2'b01, 9);  tick("R4");
    drive(2'b01, 3);  repeat (4) tick("R5");

    // R6: inverted limits raise both flags
    drive(2'b01, -9); repeat (3) tick("R6");
    hi = -16'sd5; lo = 16'sd5;
    drive(2'b01, 0);  repeat (4) tick("R6");
    drive(2'b01, 10); repeat (3) tick("R6");
    drive(2'b01, -10); repeat (3) tick("R6");
    drive(2'b01, 0);  repeat (3) tick("R6");

    // R11: code and current change every clock
    hi = 16'sd3; lo = -16'sd3;
    lf = 16'hace1;
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf[6:5], int'($signed(lf[3:0])));
      tick("R11");
    end
    drive(2'b01, 0);
    repeat (4) tick("R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule